// File: doc/BRIEF.md
# DRAM Multi-Phase Command Steerer

This block routes controller commands onto a multi-phase memory command interface. Each controller clock carries several command slots, called phases. A 2-bit select per phase picks which of four sources drives that slot. The four sources are an idle (no-operation) slot, the command chooser, the request chooser and the refresher.

For the chosen source, the block does four things:
- It inverts the active-high column, row and write-enable bits into active-low strobes.
- It splits the rank number out of the upper bank-address bits and turns it into active-low chip selects.
- It forwards the read and write data-enable flags.
- It registers every phase output.

A strobe or data enable only leaves the block when its source shows valid and ready in the same cycle. The address and bank still follow the selected source either way.

The reset, clock-enable and termination lines are held at fixed inactive-safe levels. Phase count, rank count and address widths are parameters. Sources are presented as packed arrays indexed by the select code. The idle slot's valid, ready and command bits are accepted but never used.

Top module: `phase_cmd_steer`

## Requirements
- R1: Each phase's 2-bit select chooses its source with code 0 = idle, 1 = command chooser, 2 = request chooser, 3 = refresher. All phase outputs are registered, so they reflect the select and source inputs present at the previous rising clock edge and hold until the next one.
- R2: A phase with select 0 drives cas_n, ras_n and we_n all 1 and both data enables 0, whatever the idle slot's valid, ready and command bits hold.
- R3: For select 1 to 3, the strobes are the inverse of the source's cas, ras and we bits only when that source's valid and ready are both 1. Otherwise all three strobes are 1.
- R4: The phase address and bank outputs follow the selected source even when its strobes are suppressed.
- R5: An activate (ras only) gives ras_n=0, cas_n=1, we_n=1. A refresh (cas and ras) gives cas_n=0, ras_n=0, we_n=1. A write (cas and we) gives cas_n=0, we_n=0, ras_n=1.
- R6: With one rank, the full bank-address field goes to the phase bank output and cs_n is 0.
- R7: With several ranks, the top clog2(ranks) bank-address bits are the rank number and the remaining low bits form the phase bank. cs_n bit r is 0 exactly for rank r. For example, with 2 ranks a 3-bit field 110 gives bank 10 and cs_n 01, and 001 gives bank 01 and cs_n 10.
- R8: When the refresher is selected and both its valid and ready are 1, cs_n is all zeros whatever the rank bits are. When it is not issued, cs_n decodes the rank as in R7.
- R9: Every phase drives reset_n 1, and cke and odt as all ones across the rank width.
- R10: A phase's read and write data enables equal the selected source's is_read and is_write bits when that source is valid and ready, and 0 otherwise.
- R11: While rst_n is low, every phase holds strobes at 1, data enables at 0, cs_n all ones, and address and bank at 0.
- R12: Phases are independent. Different phases may select different sources, or the same source, in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_sel | input | NUM_PHASES*2 | Source select, phase p at bits [2p+1:2p] |
| src_valid | input | 4 | Valid per source, indexed by select code |
| src_ready | input | 4 | Ready per source |
| src_cas | input | 4 | Active-high column strobe per source |
| src_ras | input | 4 | Active-high row strobe per source |
| src_we | input | 4 | Active-high write enable per source |
| src_is_read | input | 4 | Read data flag per source |
| src_is_write | input | 4 | Write data flag per source |
| src_addr | input | 4*ADDR_W | Address per source, source s at [s*ADDR_W +: ADDR_W] |
| src_ba | input | 4*BA_W | Bank address including rank bits, per source |
| ph_addr | output | NUM_PHASES*ADDR_W | Registered address per phase |
| ph_bank | output | NUM_PHASES*BANK_OUT_W | Registered bank per phase |
| ph_cs_n | output | NUM_PHASES*NUM_RANKS | Active-low chip selects per phase |
| ph_cas_n | output | NUM_PHASES | Active-low column strobe per phase |
| ph_ras_n | output | NUM_PHASES | Active-low row strobe per phase |
| ph_we_n | output | NUM_PHASES | Active-low write enable per phase |
| ph_rden | output | NUM_PHASES | Read data enable per phase |
| ph_wren | output | NUM_PHASES | Write data enable per phase |
| ph_cke | output | NUM_PHASES*NUM_RANKS | Clock enable, constant ones |
| ph_odt | output | NUM_PHASES*NUM_RANKS | Termination, constant ones |
| ph_reset_n | output | NUM_PHASES | Memory reset, constant ones |

## Verification
The bench targets the split between valid-without-ready and valid-with-ready. A design that ignored ready would emit a row strobe on the first test cycle, while one that gated the address as well would lose the forwarded address and bank. Rank decoding is checked with bank values whose rank bit and low bits disagree. Wrong bit slicing shows up as a swapped cs_n pattern or a bank still carrying the rank bit.

Refresh is tried both issued and stalled. A design that forced all ranks regardless of ready, or never forced them, gives the wrong cs_n in one of the two cases. A second instance with a single rank catches a design that still strips a rank bit from the bank. Data enables are checked against stalled sources. A design that let a stalled read or write through would show up there.

// File: rtl/dram_steer_pkg.sv
// Shared encodings for the phase command steerer.
package dram_steer_pkg;

    localparam int SEL_W     = 2;
    localparam int SRC_COUNT = 4;

    // Select code per phase; the numeric values are the source array index (R1).
    typedef enum logic [SEL_W-1:0] {
        SRC_IDLE = 2'd0,
        SRC_CMD  = 2'd1,
        SRC_REQ  = 2'd2,
        SRC_REF  = 2'd3
    } steer_src_e;

endpackage

// File: rtl/steer_cmd_gate.sv
// Converts one source's active-high command bits into active-low strobes
// and data enables, gated by valid and ready.
// Assumes: is_idle marks the no-operation slot, whose bits are ignored.
module steer_cmd_gate (
    input  logic is_idle,
    input  logic valid,
    input  logic ready,
    input  logic cas,
    input  logic ras,
    input  logic we,
    input  logic is_read,
    input  logic is_write,
    output logic issue,
    output logic cas_n,
    output logic ras_n,
    output logic we_n,
    output logic rden,
    output logic wren
);

    // Decide whether the command leaves, then invert or park the strobes (R2, R3, R5, R10).
    always_comb begin
        issue = !is_idle && valid && ready;
        cas_n = issue ? ~cas : 1'b1;
        ras_n = issue ? ~ras : 1'b1;
        we_n  = issue ? ~we  : 1'b1;
        rden  = issue && is_read;
        wren  = issue && is_write;
    end

endmodule

// File: rtl/steer_rank_split.sv
// Splits a bank-address field into device bank bits and active-low chip
// selects. With one rank the whole field is the bank and cs_n is 0.
// Assumes: the rank number sits in the top bits of the field.
module steer_rank_split #(
    parameter int BA_W       = 3,
    parameter int NUM_RANKS  = 2,
    localparam int RANK_W     = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 0,
    localparam int BANK_OUT_W = BA_W - RANK_W
) (
    input  logic [BA_W-1:0]       ba,
    input  logic                  all_ranks,
    output logic [BANK_OUT_W-1:0] bank,
    output logic [NUM_RANKS-1:0]  cs_n
);

    generate
        if (NUM_RANKS > 1) begin : g_multi
            logic [RANK_W-1:0] rank;
            // Separate rank and bank bits, decode one-hot, force all on refresh (R7, R8).
            always_comb begin
                rank = ba[BA_W-1 -: RANK_W];
                bank = ba[BANK_OUT_W-1:0];
                if (all_ranks)
                    cs_n = '0;
                else
                    cs_n = ~(NUM_RANKS'(1) << rank);
            end
        end else begin : g_single
            // Pass the full field through; the single rank stays selected (R6).
            always_comb begin
                bank = ba;
                cs_n = '0;
                if (all_ranks) cs_n = '0;
            end
        end
    endgenerate

endmodule

// File: rtl/steer_phase_lane.sv
// One command phase: selects a source, gates and decodes it, registers the result.
// Assumes: source arrays are indexed by the select code.
module steer_phase_lane import dram_steer_pkg::*; #(
    parameter int ADDR_W     = 13,
    parameter int BA_W       = 3,
    parameter int NUM_RANKS  = 2,
    localparam int RANK_W     = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 0,
    localparam int BANK_OUT_W = BA_W - RANK_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SEL_W-1:0]            sel,
    input  logic [SRC_COUNT-1:0]        src_valid,
    input  logic [SRC_COUNT-1:0]        src_ready,
    input  logic [SRC_COUNT-1:0]        src_cas,
    input  logic [SRC_COUNT-1:0]        src_ras,
    input  logic [SRC_COUNT-1:0]        src_we,
    input  logic [SRC_COUNT-1:0]        src_is_read,
    input  logic [SRC_COUNT-1:0]        src_is_write,
    input  logic [SRC_COUNT*ADDR_W-1:0] src_addr,
    input  logic [SRC_COUNT*BA_W-1:0]   src_ba,
    output logic [ADDR_W-1:0]           addr_q,
    output logic [BANK_OUT_W-1:0]       bank_q,
    output logic [NUM_RANKS-1:0]        cs_n_q,
    output logic                        cas_n_q,
    output logic                        ras_n_q,
    output logic                        we_n_q,
    output logic                        rden_q,
    output logic                        wren_q
);

    logic              m_valid, m_ready, m_cas, m_ras, m_we, m_rd, m_wr;
    logic [ADDR_W-1:0] m_addr;
    logic [BA_W-1:0]   m_ba;
    logic              is_idle, is_ref, issue;
    logic              cas_n_d, ras_n_d, we_n_d, rden_d, wren_d;
    logic [BANK_OUT_W-1:0] bank_d;
    logic [NUM_RANKS-1:0]  cs_n_d;

    // Pick the fields of the selected source (R1, R12).
    always_comb begin
        m_valid = src_valid[sel];
        m_ready = src_ready[sel];
        m_cas   = src_cas[sel];
        m_ras   = src_ras[sel];
        m_we    = src_we[sel];
        m_rd    = src_is_read[sel];
        m_wr    = src_is_write[sel];
        m_addr  = src_addr[sel*ADDR_W +: ADDR_W];
        m_ba    = src_ba[sel*BA_W +: BA_W];
        is_idle = (sel == SRC_IDLE);
        is_ref  = (sel == SRC_REF);
    end

    steer_cmd_gate u_gate (
        .is_idle  (is_idle),
        .valid    (m_valid),
        .ready    (m_ready),
        .cas      (m_cas),
        .ras      (m_ras),
        .we       (m_we),
        .is_read  (m_rd),
        .is_write (m_wr),
        .issue    (issue),
        .cas_n    (cas_n_d),
        .ras_n    (ras_n_d),
        .we_n     (we_n_d),
        .rden     (rden_d),
        .wren     (wren_d)
    );

    steer_rank_split #(
        .BA_W      (BA_W),
        .NUM_RANKS (NUM_RANKS)
    ) u_rank (
        .ba        (m_ba),
        .all_ranks (is_ref && issue),
        .bank      (bank_d),
        .cs_n      (cs_n_d)
    );

    // Register the phase outputs; reset parks them inactive (R1, R11).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            bank_q  <= '0;
            cs_n_q  <= '1;
            cas_n_q <= 1'b1;
            ras_n_q <= 1'b1;
            we_n_q  <= 1'b1;
            rden_q  <= 1'b0;
            wren_q  <= 1'b0;
        end else begin
            addr_q  <= m_addr;
            bank_q  <= bank_d;
            cs_n_q  <= cs_n_d;
            cas_n_q <= cas_n_d;
            ras_n_q <= ras_n_d;
            we_n_q  <= we_n_d;
            rden_q  <= rden_d;
            wren_q  <= wren_d;
        end
    end

    // R2: idle select leaves all strobes and enables inactive.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel) == SRC_IDLE)
        |-> (cas_n_q && ras_n_q && we_n_q && !rden_q && !wren_q));

    // R3: a source lacking valid or ready produces no strobe.
    a_r3_no_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(src_valid[sel]) && $past(src_ready[sel])))
        |-> (cas_n_q && ras_n_q && we_n_q));

    // R4: address follows the selected source one cycle later.
    a_r4_addr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> addr_q == $past(src_addr[sel*ADDR_W +: ADDR_W]));

    // R8: an issued refresh selects every rank.
    a_r8_refresh_all: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel) == SRC_REF && $past(src_valid[SRC_REF])
         && $past(src_ready[SRC_REF])) |-> cs_n_q == '0);

    // R10: data enables never rise without a valid and ready source.
    a_r10_enable_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(src_valid[sel]) && $past(src_ready[sel])))
        |-> (!rden_q && !wren_q));

    generate
        if (NUM_RANKS > 1) begin : g_cs_chk
            // R7: at most one rank selected outside an issued refresh.
            a_r7_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(sel) != SRC_REF) |-> $onehot0(~cs_n_q));
        end
    endgenerate

endmodule

// File: rtl/phase_cmd_steer.sv
// Multi-phase command steerer: one lane per phase plus static control lines.
// Assumes: source index in every src_* array equals the select code.
module phase_cmd_steer import dram_steer_pkg::*; #(
    parameter int NUM_PHASES = 4,
    parameter int NUM_RANKS  = 2,
    parameter int ADDR_W     = 13,
    parameter int BA_W       = 3,
    localparam int RANK_W     = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 0,
    localparam int BANK_OUT_W = BA_W - RANK_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PHASES*SEL_W-1:0]      phase_sel,
    input  logic [SRC_COUNT-1:0]             src_valid,
    input  logic [SRC_COUNT-1:0]             src_ready,
    input  logic [SRC_COUNT-1:0]             src_cas,
    input  logic [SRC_COUNT-1:0]             src_ras,
    input  logic [SRC_COUNT-1:0]             src_we,
    input  logic [SRC_COUNT-1:0]             src_is_read,
    input  logic [SRC_COUNT-1:0]             src_is_write,
    input  logic [SRC_COUNT*ADDR_W-1:0]      src_addr,
    input  logic [SRC_COUNT*BA_W-1:0]        src_ba,
    output logic [NUM_PHASES*ADDR_W-1:0]     ph_addr,
    output logic [NUM_PHASES*BANK_OUT_W-1:0] ph_bank,
    output logic [NUM_PHASES*NUM_RANKS-1:0]  ph_cs_n,
    output logic [NUM_PHASES-1:0]            ph_cas_n,
    output logic [NUM_PHASES-1:0]            ph_ras_n,
    output logic [NUM_PHASES-1:0]            ph_we_n,
    output logic [NUM_PHASES-1:0]            ph_rden,
    output logic [NUM_PHASES-1:0]            ph_wren,
    output logic [NUM_PHASES*NUM_RANKS-1:0]  ph_cke,
    output logic [NUM_PHASES*NUM_RANKS-1:0]  ph_odt,
    output logic [NUM_PHASES-1:0]            ph_reset_n
);

    // Static control lines held at their run levels (R9).
    assign ph_cke     = '1;
    assign ph_odt     = '1;
    assign ph_reset_n = '1;

    generate
        for (genvar p = 0; p < NUM_PHASES; p++) begin : g_lane
            steer_phase_lane #(
                .ADDR_W    (ADDR_W),
                .BA_W      (BA_W),
                .NUM_RANKS (NUM_RANKS)
            ) u_lane (
                .clk          (clk),
                .rst_n        (rst_n),
                .sel          (phase_sel[p*SEL_W +: SEL_W]),
                .src_valid    (src_valid),
                .src_ready    (src_ready),
                .src_cas      (src_cas),
                .src_ras      (src_ras),
                .src_we       (src_we),
                .src_is_read  (src_is_read),
                .src_is_write (src_is_write),
                .src_addr     (src_addr),
                .src_ba       (src_ba),
                .addr_q       (ph_addr[p*ADDR_W +: ADDR_W]),
                .bank_q       (ph_bank[p*BANK_OUT_W +: BANK_OUT_W]),
                .cs_n_q       (ph_cs_n[p*NUM_RANKS +: NUM_RANKS]),
                .cas_n_q      (ph_cas_n[p]),
                .ras_n_q      (ph_ras_n[p]),
                .we_n_q       (ph_we_n[p]),
                .rden_q       (ph_rden[p]),
                .wren_q       (ph_wren[p])
            );
        end
    endgenerate

endmodule

// File: tb/tb_phase_cmd_steer.sv
`timescale 1ns/1ps
module tb_phase_cmd_steer;

    localparam int P = 4;
    localparam int A = 13;
    localparam int B = 3;

    logic clk = 0;
    logic rst_n = 0;
    logic [P*2-1:0] phase_sel = '0;
    logic [3:0] src_valid = '0, src_ready = '0, src_cas = '0, src_ras = '0, src_we = '0;
    logic [3:0] src_is_read = '0, src_is_write = '0;
    logic [4*A-1:0] src_addr = '0;
    logic [4*B-1:0] src_ba = '0;

    logic [P*A-1:0] ph_addr, s_addr;
    logic [P*2-1:0] ph_bank, ph_cs_n, ph_cke, ph_odt;
    logic [P*3-1:0] s_bank;
    logic [P-1:0]   s_cs_n, s_cke, s_odt, s_cas_n, s_ras_n, s_we_n, s_rden, s_wren, s_reset_n;
    logic [P-1:0]   ph_cas_n, ph_ras_n, ph_we_n, ph_rden, ph_wren, ph_reset_n;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    phase_cmd_steer #(.NUM_PHASES(P), .NUM_RANKS(2), .ADDR_W(A), .BA_W(B)) dut (
        .clk(clk), .rst_n(rst_n), .phase_sel(phase_sel),
        .src_valid(src_valid), .src_ready(src_ready), .src_cas(src_cas), .src_ras(src_ras),
        .src_we(src_we), .src_is_read(src_is_read), .src_is_write(src_is_write),
        .src_addr(src_addr), .src_ba(src_ba),
        .ph_addr(ph_addr), .ph_bank(ph_bank), .ph_cs_n(ph_cs_n), .ph_cas_n(ph_cas_n),
        .ph_ras_n(ph_ras_n), .ph_we_n(ph_we_n), .ph_rden(ph_rden), .ph_wren(ph_wren),
        .ph_cke(ph_cke), .ph_odt(ph_odt), .ph_reset_n(ph_reset_n));

    phase_cmd_steer #(.NUM_PHASES(P), .NUM_RANKS(1), .ADDR_W(A), .BA_W(B)) dut_single (
        .clk(clk), .rst_n(rst_n), .phase_sel(phase_sel),
        .src_valid(src_valid), .src_ready(src_ready), .src_cas(src_cas), .src_ras(src_ras),
        .src_we(src_we), .src_is_read(src_is_read), .src_is_write(src_is_write),
        .src_addr(src_addr), .src_ba(src_ba),
        .ph_addr(s_addr), .ph_bank(s_bank), .ph_cs_n(s_cs_n), .ph_cas_n(s_cas_n),
        .ph_ras_n(s_ras_n), .ph_we_n(s_we_n), .ph_rden(s_rden), .ph_wren(s_wren),
        .ph_cke(s_cke), .ph_odt(s_odt), .ph_reset_n(s_reset_n));

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_src();
        src_valid = '0; src_ready = '0; src_cas = '0; src_ras = '0; src_we = '0;
        src_is_read = '0; src_is_write = '0; src_addr = '0; src_ba = '0; phase_sel = '0;
    endtask

    task automatic set_src(input int s, input bit v, input bit r, input bit c, input bit ra,
                           input bit w, input bit rd, input bit wr,
                           input logic [A-1:0] a, input logic [B-1:0] b);
        src_valid[s] = v; src_ready[s] = r; src_cas[s] = c; src_ras[s] = ra; src_we[s] = w;
        src_is_read[s] = rd; src_is_write[s] = wr;
        src_addr[s*A +: A] = a; src_ba[s*B +: B] = b;
    endtask

    task automatic set_sel(input int p, input logic [1:0] v);
        phase_sel[p*2 +: 2] = v;
    endtask

    task automatic t_reset();
        set_src(1, 1, 1, 1, 1, 1, 1, 1, 13'h5, 3'b101);
        set_sel(0, 2'd1);
        step();
        chk("R11 strobes in reset", {ph_cas_n, ph_ras_n, ph_we_n}, 12'hFFF);
        chk("R11 cs_n in reset", ph_cs_n, 8'hFF);
        chk("R11 enables in reset", {ph_rden, ph_wren}, 8'h00);
        chk("R11 addr in reset", ph_addr[A-1:0], 0);
        chk("R11 bank in reset", ph_bank, 0);
        clear_src();
    endtask

    task automatic t_idle();
        clear_src();
        set_src(0, 1, 1, 1, 1, 1, 1, 1, 13'h44, 3'b000);
        step();
        chk("R2 idle strobes", {ph_cas_n, ph_ras_n, ph_we_n}, 12'hFFF);
        chk("R2 idle enables", {ph_rden, ph_wren}, 8'h00);
        chk("R4 idle addr", ph_addr[A-1:0], 13'h44);
    endtask

    task automatic t_handshake();
        clear_src();
        set_src(1, 1, 0, 0, 1, 0, 0, 0, 13'h1, 3'b001);
        set_sel(0, 2'd1);
        step();
        chk("R3 not ready ras_n", ph_ras_n[0], 1);
        chk("R3 not ready cas_n", ph_cas_n[0], 1);
        chk("R4 addr when stalled", ph_addr[A-1:0], 13'h1);
        chk("R4 bank when stalled", ph_bank[1:0], 2'b01);
        chk("R7 cs_n when stalled", ph_cs_n[1:0], 2'b10);
        src_ready[1] = 1;
        step();
        chk("R5 activate strobes", {ph_cas_n[0], ph_ras_n[0], ph_we_n[0]}, 3'b101);
        src_valid[1] = 0;
        step();
        chk("R3 not valid strobes", {ph_cas_n[0], ph_ras_n[0], ph_we_n[0]}, 3'b111);
    endtask

    task automatic t_rank();
        logic [B-1:0] bas [3]   = '{3'b110, 3'b101, 3'b001};
        logic [1:0]   banks [3] = '{2'b10, 2'b01, 2'b01};
        logic [1:0]   csn [3]   = '{2'b01, 2'b01, 2'b10};
        clear_src();
        set_sel(1, 2'd1);
        for (int i = 0; i < 3; i++) begin
            set_src(1, 1, 1, 0, 1, 0, 0, 0, 13'h1, bas[i]);
            step();
            chk("R7 bank split", ph_bank[3:2], banks[i]);
            chk("R7 cs_n decode", ph_cs_n[3:2], csn[i]);
            chk("R5 activate phase1", {ph_cas_n[1], ph_ras_n[1], ph_we_n[1]}, 3'b101);
        end
    endtask

    task automatic t_refresh();
        logic [B-1:0] bas [3]   = '{3'b110, 3'b101, 3'b001};
        logic [1:0]   banks [3] = '{2'b10, 2'b01, 2'b01};
        clear_src();
        set_sel(0, 2'd3);
        for (int i = 0; i < 3; i++) begin
            set_src(3, 1, 1, 1, 1, 0, 0, 0, 13'h3, bas[i]);
            step();
            chk("R8 refresh all ranks", ph_cs_n[1:0], 2'b00);
            chk("R5 refresh strobes", {ph_cas_n[0], ph_ras_n[0], ph_we_n[0]}, 3'b001);
            chk("R7 refresh bank", ph_bank[1:0], banks[i]);
        end
        set_src(3, 1, 0, 1, 1, 0, 0, 0, 13'h3, 3'b110);
        step();
        chk("R8 stalled refresh decodes rank", ph_cs_n[1:0], 2'b01);
        chk("R3 stalled refresh strobes", {ph_cas_n[0], ph_ras_n[0], ph_we_n[0]}, 3'b111);
    endtask

    task automatic t_data_en();
        clear_src();
        set_sel(2, 2'd2);
        set_src(2, 1, 1, 1, 0, 1, 0, 1, 13'h2, 3'b010);
        step();
        chk("R10 write enable", {ph_rden[2], ph_wren[2]}, 2'b01);
        chk("R5 write strobes", {ph_cas_n[2], ph_ras_n[2], ph_we_n[2]}, 3'b010);
        set_src(2, 1, 1, 1, 0, 0, 1, 0, 13'h2, 3'b010);
        step();
        chk("R10 read enable", {ph_rden[2], ph_wren[2]}, 2'b10);
        set_src(2, 1, 0, 1, 0, 0, 1, 1, 13'h2, 3'b010);
        step();
        chk("R10 stalled enables", {ph_rden[2], ph_wren[2]}, 2'b00);
    endtask

    task automatic t_phases();
        clear_src();
        set_src(0, 0, 0, 0, 0, 0, 0, 0, 13'h44, 3'b000);
        set_src(1, 0, 0, 0, 0, 0, 0, 0, 13'h11, 3'b000);
        set_src(2, 0, 0, 0, 0, 0, 0, 0, 13'h22, 3'b000);
        set_src(3, 0, 0, 0, 0, 0, 0, 0, 13'h33, 3'b000);
        set_sel(0, 2'd1); set_sel(1, 2'd2); set_sel(2, 2'd3); set_sel(3, 2'd1);
        step();
        chk("R12 phase0 addr", ph_addr[0*A +: A], 13'h11);
        chk("R12 phase1 addr", ph_addr[1*A +: A], 13'h22);
        chk("R12 phase2 addr", ph_addr[2*A +: A], 13'h33);
        chk("R12 phase3 shares source", ph_addr[3*A +: A], 13'h11);
        set_sel(0, 2'd0);
        #1;
        chk("R1 holds until edge", ph_addr[0*A +: A], 13'h11);
        step();
        chk("R1 updates after edge", ph_addr[0*A +: A], 13'h44);
    endtask

    task automatic t_static();
        chk("R9 reset_n", ph_reset_n, 4'hF);
        chk("R9 cke", ph_cke, 8'hFF);
        chk("R9 odt", ph_odt, 8'hFF);
        chk("R9 single cke", s_cke, 4'hF);
    endtask

    task automatic t_single();
        clear_src();
        set_sel(1, 2'd1);
        set_src(1, 1, 1, 0, 1, 0, 0, 0, 13'h1, 3'b110);
        step();
        chk("R6 single bank full", s_bank[5:3], 3'b110);
        chk("R6 single cs_n", s_cs_n[1], 0);
        chk("R6 single activate", s_ras_n[1], 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        step();
        t_reset();
        rst_n = 1;
        t_idle();
        t_handshake();
        t_rank();
        t_refresh();
        t_data_en();
        t_phases();
        t_static();
        t_single();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule